// File: doc/BRIEF.md
# Keyed Configuration Access Port

This block puts a configuration register space behind a two-address byte window. Address 0 of the window is the index/key port and address 1 is the data port. After reset the space is sealed. A host opens it by writing the enter key to the index port on two consecutive index writes. While the space is open, an index-port write chooses which configuration register the data port reaches. Data-port reads and writes then access that register. Writing the leave key to the index port seals the space again.

Logical devices share the window. A select register decides which device's bank answers for indices 0x30 and above. The block implements one device bank, a watchdog bank that holds a single activate bit. It also presents every device-range data write on a strobe interface, so that banks outside the block can decode the write. A read-only chip identifier sits in the global space. A parameter chooses the key pair: the standard pair is 0x87/0xAA and the alternate pair is 0x88/0xBB.

Top module: `cfgport_top`

## Requirements
- R1: After reset the space is sealed, the logical-device select is 0x00, the index is 0x00 and the activate bit is 0.
- R2: Two consecutive index-port writes of the enter key (0x87 standard) open the space. A single enter-key write leaves it sealed.
- R3: While sealed, an index-port write of any byte other than the enter key discards the key progress, so two further enter keys are needed. Data-port accesses neither advance nor discard the progress.
- R4: While open, an index-port write of the leave key (0xAA standard) seals the space and clears the index to 0x00. A later reopening reads the index back as 0x00.
- R5: While sealed, index-port and data-port reads return 0xFF, and data-port writes change no register.
- R6: With ALT_KEYS=1 the keys are 0x88 to enter and 0xBB to leave. The standard enter key then does not open the space.
- R7: Index 0x07 is the logical-device select register. It is read/write through the data port and drives `ld_select`.
- R8: Index 0x20 reads the CHIP_ID parameter. Writes to it are discarded.
- R9: Index 0x30 reads {7'b0, activate} when the logical-device select equals WDG_LDN (default 0x08). A write there sets the activate bit from data bit 0. With any other device selected, that index reads 0x00 and writes leave the activate bit unchanged.
- R10: A data-port read of an unimplemented index returns 0x00, and a write to one is discarded.
- R11: `cfg_we` is high, combinationally, exactly during a data-port write while the space is open and the index is 0x30 or above. During that write `cfg_index` carries the index and `cfg_wdata` carries the byte.
- R12: While open, an index-port read returns the current index. An enter-key byte written while open is stored as an index. `bus_rdata` is 0x00 when no read is active or when a write is presented in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | 1 | 0 selects the index/key port, 1 selects the data port |
| bus_wr | input | 1 | Byte write strobe, one cycle per write |
| bus_rd | input | 1 | Byte read strobe |
| bus_wdata | input | 8 | Write byte |
| bus_rdata | output | 8 | Read byte, valid in the cycle of the read |
| ld_select | output | 8 | Current logical-device select |
| cfg_we | output | 1 | Device-range write strobe |
| cfg_index | output | 8 | Current configuration index |
| cfg_wdata | output | 8 | Byte carried with `cfg_we` |
| wdg_active | output | 1 | Watchdog bank activate bit |

## Verification
The bench goes after the key sequencer's edge cases: a lone enter key, a stray byte between two enter keys, and data-port traffic between the keys. A tracker that counted keys without requiring them to be consecutive would open early, and a tracker that reset on data accesses would stay sealed. The bench also runs a standard-key and an alternate-key instance side by side, so a key pair that is crossed or hard-wired shows up as the wrong instance opening. It checks that the index is cleared on sealing, that sealed reads return 0xFF, and that the activate bit does not move while a different logical device is selected. A design that leaked writes across devices, or that kept a stale index, would return bytes that differ from the model's.

// File: rtl/cfgport_pkg.sv
// Shared constants for the keyed configuration port.
// Assumes 8-bit configuration bytes and 8-bit register indices.
package cfgport_pkg;
    localparam int CFG_W = 8;

    typedef enum logic [1:0] {
        LK_SEALED = 2'd0,
        LK_HALF   = 2'd1,
        LK_OPEN   = 2'd2
    } lock_state_t;

    localparam logic [CFG_W-1:0] KEY_ENTER_STD = 8'h87;
    localparam logic [CFG_W-1:0] KEY_LEAVE_STD = 8'hAA;
    localparam logic [CFG_W-1:0] KEY_ENTER_ALT = 8'h88;
    localparam logic [CFG_W-1:0] KEY_LEAVE_ALT = 8'hBB;

    localparam logic [CFG_W-1:0] IDX_LDSEL  = 8'h07;
    localparam logic [CFG_W-1:0] IDX_CHIPID = 8'h20;
    localparam logic [CFG_W-1:0] IDX_ACT    = 8'h30;
    localparam logic [CFG_W-1:0] IDX_DEV_LO = 8'h30;
    localparam logic [CFG_W-1:0] SEALED_RD  = 8'hFF;
endpackage

// File: rtl/cfgport_keyfsm.sv
// Key sequencer: tracks enter-key progress on index-port writes and
// opens or seals the configuration space.
// Assumes one index write per strobe cycle; data-port traffic is not seen here.
module cfgport_keyfsm
    import cfgport_pkg::*;
#(
    parameter bit ALT_KEYS = 1'b0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             idx_wr,
    input  logic [CFG_W-1:0] wdata,
    output logic             is_open,
    output logic             closing
);
    logic [CFG_W-1:0] enter_k;
    logic [CFG_W-1:0] leave_k;
    lock_state_t      st;

    generate
        if (ALT_KEYS) begin : g_alt_keys
            assign enter_k = KEY_ENTER_ALT;
            assign leave_k = KEY_LEAVE_ALT;
        end else begin : g_std_keys
            assign enter_k = KEY_ENTER_STD;
            assign leave_k = KEY_LEAVE_STD;
        end
    endgenerate

    // Advance, restart or close the lock on each index-port write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st <= LK_SEALED;
        end else if (idx_wr) begin
            case (st)
                LK_SEALED: st <= (wdata == enter_k) ? LK_HALF : LK_SEALED;
                LK_HALF:   st <= (wdata == enter_k) ? LK_OPEN : LK_SEALED;
                LK_OPEN:   st <= (wdata == leave_k) ? LK_SEALED : LK_OPEN;
                default:   st <= LK_SEALED;
            endcase
        end
    end

    assign is_open = (st == LK_OPEN);
    assign closing = idx_wr && is_open && (wdata == leave_k);

    // R2: one enter key from the sealed state never opens.
    a_r2_single_key_sealed: assert property (@(posedge clk) disable iff (!rst_n)
        (st == LK_SEALED && idx_wr) |=> (st != LK_OPEN));
    // R2: the second consecutive enter key opens.
    a_r2_second_key_opens: assert property (@(posedge clk) disable iff (!rst_n)
        (st == LK_HALF && idx_wr && wdata == enter_k) |=> (st == LK_OPEN));
    // R3: a stray index byte while sealed drops all progress.
    a_r3_stray_restarts: assert property (@(posedge clk) disable iff (!rst_n)
        (st != LK_OPEN && idx_wr && wdata != enter_k) |=> (st == LK_SEALED));
    // R3: without an index write the lock does not move.
    a_r3_idle_holds: assert property (@(posedge clk) disable iff (!rst_n)
        !idx_wr |=> $stable(st));
    // R4: the leave key seals an open space.
    a_r4_leave_seals: assert property (@(posedge clk) disable iff (!rst_n)
        (st == LK_OPEN && idx_wr && wdata == leave_k) |=> (st == LK_SEALED));
endmodule

// File: rtl/cfgport_globals.sv
// Global registers: index, logical-device select, chip identifier, and the
// read multiplexer for both window addresses.
// Assumes device-range reads (index 0x30 and up) are answered on dev_rdata.
module cfgport_globals
    import cfgport_pkg::*;
#(
    parameter logic [CFG_W-1:0] CHIP_ID = 8'h5A
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             is_open,
    input  logic             closing,
    input  logic             idx_wr,
    input  logic             dat_wr,
    input  logic             idx_rd,
    input  logic             dat_rd,
    input  logic [CFG_W-1:0] wdata,
    input  logic [CFG_W-1:0] dev_rdata,
    output logic [CFG_W-1:0] index,
    output logic [CFG_W-1:0] ld_select,
    output logic [CFG_W-1:0] rdata
);
    // Hold the selected index; cleared when the space seals.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            index <= '0;
        end else if (closing) begin
            index <= '0;
        end else if (is_open && idx_wr) begin
            index <= wdata;
        end
    end

    // Logical-device select, written only through the open data port.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ld_select <= '0;
        end else if (is_open && dat_wr && index == IDX_LDSEL) begin
            ld_select <= wdata;
        end
    end

    // Read multiplexer for the index and data addresses.
    always_comb begin
        rdata = '0;
        if (idx_rd) begin
            rdata = is_open ? index : SEALED_RD;
        end else if (dat_rd) begin
            if (!is_open) begin
                rdata = SEALED_RD;
            end else if (index == IDX_LDSEL) begin
                rdata = ld_select;
            end else if (index == IDX_CHIPID) begin
                rdata = CHIP_ID;
            end else if (index >= IDX_DEV_LO) begin
                rdata = dev_rdata;
            end
        end
    end

    // R5 and R7: the device select cannot move while sealed.
    a_r7_ldsel_sealed_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !is_open |=> $stable(ld_select));
    // R4: sealing leaves the index at zero.
    a_r4_index_cleared: assert property (@(posedge clk) disable iff (!rst_n)
        closing |=> (index == '0));
    // R5: a sealed space keeps its index at zero.
    a_r5_index_sealed_zero: assert property (@(posedge clk) disable iff (!rst_n)
        !is_open |=> (is_open || index == '0));
endmodule

// File: rtl/cfgport_wdgbank.sv
// Watchdog logical-device bank: one activate bit at index 0x30, answering
// only while its device number is selected.
// Assumes cfg_we is already qualified by the open state and the device range.
module cfgport_wdgbank
    import cfgport_pkg::*;
#(
    parameter logic [CFG_W-1:0] WDG_LDN = 8'h08
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CFG_W-1:0] ld_select,
    input  logic             cfg_we,
    input  logic [CFG_W-1:0] cfg_index,
    input  logic             wr_bit,
    output logic             active,
    output logic [CFG_W-1:0] rdata
);
    logic selected;
    logic hit_act;

    assign selected = (ld_select == WDG_LDN);
    assign hit_act  = selected && (cfg_index == IDX_ACT);

    // Activate bit, set or cleared by a device write to its index.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active <= 1'b0;
        end else if (cfg_we && hit_act) begin
            active <= wr_bit;
        end
    end

    // Bank read data; zero for every other index or device.
    always_comb begin
        rdata = '0;
        if (hit_act) begin
            rdata = {{(CFG_W-1){1'b0}}, active};
        end
    end

    // R9: no write to this device, no change of the activate bit.
    a_r9_act_needs_write: assert property (@(posedge clk) disable iff (!rst_n)
        !(cfg_we && selected) |=> $stable(active));
    // R9: a write to the activate index takes data bit 0.
    a_r9_act_follows_write: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_we && hit_act) |=> (active == $past(wr_bit)));
endmodule

// File: rtl/cfgport_top.sv
// Keyed configuration port: two-address byte window, key-gated access,
// global registers, one watchdog bank and a device write strobe.
// Assumes a single-cycle write or read strobe per byte; write wins if both.
module cfgport_top
    import cfgport_pkg::*;
#(
    parameter bit               ALT_KEYS = 1'b0,
    parameter logic [CFG_W-1:0] CHIP_ID  = 8'h5A,
    parameter logic [CFG_W-1:0] WDG_LDN  = 8'h08
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bus_addr,
    input  logic             bus_wr,
    input  logic             bus_rd,
    input  logic [CFG_W-1:0] bus_wdata,
    output logic [CFG_W-1:0] bus_rdata,
    output logic [CFG_W-1:0] ld_select,
    output logic             cfg_we,
    output logic [CFG_W-1:0] cfg_index,
    output logic [CFG_W-1:0] cfg_wdata,
    output logic             wdg_active
);
    logic             idx_wr, dat_wr, idx_rd, dat_rd;
    logic             is_open, closing;
    logic [CFG_W-1:0] index;
    logic [CFG_W-1:0] bank_rdata;

    assign idx_wr = bus_wr && !bus_addr;
    assign dat_wr = bus_wr && bus_addr;
    assign idx_rd = bus_rd && !bus_wr && !bus_addr;
    assign dat_rd = bus_rd && !bus_wr && bus_addr;

    cfgport_keyfsm #(.ALT_KEYS(ALT_KEYS)) u_keys (
        .clk     (clk),
        .rst_n   (rst_n),
        .idx_wr  (idx_wr),
        .wdata   (bus_wdata),
        .is_open (is_open),
        .closing (closing)
    );

    cfgport_globals #(.CHIP_ID(CHIP_ID)) u_glob (
        .clk       (clk),
        .rst_n     (rst_n),
        .is_open   (is_open),
        .closing   (closing),
        .idx_wr    (idx_wr),
        .dat_wr    (dat_wr),
        .idx_rd    (idx_rd),
        .dat_rd    (dat_rd),
        .wdata     (bus_wdata),
        .dev_rdata (bank_rdata),
        .index     (index),
        .ld_select (ld_select),
        .rdata     (bus_rdata)
    );

    assign cfg_we    = dat_wr && is_open && (index >= IDX_DEV_LO);
    assign cfg_index = index;
    assign cfg_wdata = bus_wdata;

    cfgport_wdgbank #(.WDG_LDN(WDG_LDN)) u_wdg (
        .clk       (clk),
        .rst_n     (rst_n),
        .ld_select (ld_select),
        .cfg_we    (cfg_we),
        .cfg_index (index),
        .wr_bit    (bus_wdata[0]),
        .active    (wdg_active),
        .rdata     (bank_rdata)
    );

    // R11: a device strobe only ever comes with a data-port write.
    a_r11_strobe_on_data_write: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_we |-> (bus_wr && bus_addr));
    // R12: no read strobe, no read data.
    a_r12_idle_rdata_zero: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_rd |-> (bus_rdata == '0));
endmodule

// File: tb/cfgport_top_tb_top.sv
`timescale 1ns/1ps
module cfgport_top_tb_top;
    localparam int CHIP = 8'h5A;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bus_addr = 1'b0, bus_wr = 1'b0, bus_rd = 1'b0;
    logic [7:0] bus_wdata = 8'h00;

    logic [7:0] rd_s, ld_s, ci_s, cd_s, rd_a, ld_a, ci_a, cd_a;
    logic       we_s, act_s, we_a, act_a;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    // model state per instance: 0 standard keys, 1 alternate keys
    int m_st[2], m_idx[2], m_ld[2], m_act[2];
    int ek[2] = '{8'h87, 8'h88};
    int lk[2] = '{8'hAA, 8'hBB};

    always #2.5 clk = ~clk;

    cfgport_top #(.ALT_KEYS(1'b0), .CHIP_ID(8'h5A)) dut_i (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(rd_s),
        .ld_select(ld_s), .cfg_we(we_s), .cfg_index(ci_s), .cfg_wdata(cd_s),
        .wdg_active(act_s));

    cfgport_top #(.ALT_KEYS(1'b1), .CHIP_ID(8'h5A)) dut_alt_i (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(rd_a),
        .ld_select(ld_a), .cfg_we(we_a), .cfg_index(ci_a), .cfg_wdata(cd_a),
        .wdg_active(act_a));

    task automatic chk(string tag, int actual, int expected);
        checks++;
        if (actual != expected) begin
            fails++;
            $display("FAIL %s actual=0x%0h expected=0x%0h t=%0t", tag, actual, expected, $time);
        end
    endtask

    function automatic int exp_rdata(int k);
        if (bus_wr || !bus_rd) return 0;
        if (!bus_addr) return (m_st[k] == 2) ? m_idx[k] : 8'hFF;
        if (m_st[k] != 2) return 8'hFF;
        if (m_idx[k] == 8'h07) return m_ld[k];
        if (m_idx[k] == 8'h20) return CHIP;
        if (m_idx[k] == 8'h30 && m_ld[k] == 8'h08) return m_act[k];
        return 0;
    endfunction

    function automatic int exp_we(int k);
        return (bus_wr && bus_addr && m_st[k] == 2 && m_idx[k] >= 8'h30) ? 1 : 0;
    endfunction

    // reference model update at each active edge
    always @(posedge clk) begin
        for (int k = 0; k < 2; k++) begin
            if (!rst_n) begin
                m_st[k] = 0; m_idx[k] = 0; m_ld[k] = 0; m_act[k] = 0;
            end else if (bus_wr && !bus_addr) begin
                if (m_st[k] == 2) begin
                    if (bus_wdata == lk[k]) begin m_st[k] = 0; m_idx[k] = 0; end
                    else m_idx[k] = bus_wdata;
                end else if (bus_wdata == ek[k]) m_st[k] = m_st[k] + 1;
                else m_st[k] = 0;
            end else if (bus_wr && bus_addr && m_st[k] == 2) begin
                if (m_idx[k] == 8'h07) m_ld[k] = bus_wdata;
                else if (m_idx[k] == 8'h30 && m_ld[k] == 8'h08) m_act[k] = bus_wdata & 1;
            end
        end
    end

    // per-clock comparison against the model, away from the active edge
    always @(negedge clk) begin
        if (rst_n) begin
            chk("R5 model rdata std", rd_s, exp_rdata(0));
            chk("R6 model rdata alt", rd_a, exp_rdata(1));
            chk("R7 model ld_select std", ld_s, m_ld[0]);
            chk("R7 model ld_select alt", ld_a, m_ld[1]);
            chk("R9 model activate std", act_s, m_act[0]);
            chk("R9 model activate alt", act_a, m_act[1]);
            chk("R11 model cfg_we std", we_s, exp_we(0));
            chk("R11 model cfg_we alt", we_a, exp_we(1));
            if (we_s) begin
                chk("R11 model cfg_index", ci_s, m_idx[0]);
                chk("R11 model cfg_wdata", cd_s, bus_wdata);
            end
        end
    end

    task automatic put(bit a, int d);
        bus_addr = a; bus_wr = 1'b1; bus_wdata = d[7:0];
        @(posedge clk); #1;
        bus_wr = 1'b0;
    endtask

    task automatic get(bit a, int e_s, int e_a, string tag);
        bus_addr = a; bus_rd = 1'b1;
        @(negedge clk);
        if (e_s >= 0) chk({tag, " std"}, rd_s, e_s);
        if (e_a >= 0) chk({tag, " alt"}, rd_a, e_a);
        @(posedge clk); #1;
        bus_rd = 1'b0;
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        chk("R1 reset ld_select", ld_s, 0);
        chk("R1 reset activate", act_s, 0);
        get(1, 8'hFF, 8'hFF, "R1 sealed after reset");

        put(0, 8'h87);
        get(1, 8'hFF, 8'hFF, "R2 one key stays sealed");
        put(0, 8'h11);
        put(0, 8'h87);
        get(0, 8'hFF, 8'hFF, "R3 stray byte restarts");
        put(1, 8'h33);
        get(1, 8'hFF, 8'hFF, "R5 data read sealed");
        put(0, 8'h87);
        get(0, 8'h00, 8'hFF, "R3 data access keeps progress");

        put(0, 8'h07); put(1, 8'h08);
        chk("R7 ld_select written", ld_s, 8'h08);
        get(1, 8'h08, -1, "R7 ld_select readback");

        put(0, 8'h20);
        get(1, CHIP, -1, "R8 chip id");
        put(1, 8'h00);
        get(1, CHIP, -1, "R8 chip id write ignored");

        put(0, 8'h30);
        bus_addr = 1'b1; bus_wr = 1'b1; bus_wdata = 8'hFF;
        @(negedge clk);
        chk("R11 strobe high", we_s, 1);
        chk("R11 strobe index", ci_s, 8'h30);
        @(posedge clk); #1 bus_wr = 1'b0;
        chk("R9 activate set", act_s, 1);
        get(1, 8'h01, -1, "R9 activate readback");

        put(0, 8'h55);
        get(1, 8'h00, -1, "R10 unimplemented reads zero");
        put(1, 8'h77);
        get(1, 8'h00, -1, "R10 unimplemented write discarded");

        put(0, 8'h07); put(1, 8'h03);
        put(0, 8'h30); put(1, 8'h00);
        chk("R9 other device leaves activate", act_s, 1);
        get(1, 8'h00, -1, "R9 other device reads zero");

        put(0, 8'h87);
        get(0, 8'h87, -1, "R12 enter key stored as index");

        put(0, 8'hAA);
        get(1, 8'hFF, 8'hFF, "R4 leave key seals");
        get(0, 8'hFF, 8'hFF, "R5 index read sealed");
        put(1, 8'h09);
        chk("R5 sealed write ignored", ld_s, 8'h03);
        put(0, 8'h87); put(0, 8'h87);
        get(0, 8'h00, 8'hFF, "R4 index cleared on reopen");
        put(0, 8'hAA);

        put(0, 8'h88); put(0, 8'h88);
        get(0, 8'hFF, 8'h00, "R6 alternate key opens");
        put(0, 8'h07); put(1, 8'h08);
        chk("R6 alt ld_select", ld_a, 8'h08);
        put(0, 8'hBB);
        get(1, 8'hFF, 8'hFF, "R6 alternate leave seals");
        put(0, 8'h87); put(0, 8'h87);
        get(1, -1, 8'hFF, "R6 standard key ignored by alt");

        repeat (2) @(posedge clk);
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL R1 watchdog actual=running expected=finished");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end
endmodule